// File: doc/BRIEF.md
# Multi-Carrier Binary FSK Modulator

This block turns a serial transmit bit stream into a phase-continuous binary FSK carrier for a power-line transmitter. A 32-bit phase accumulator, clocked at 16 MHz, advances by a per-cycle step. The step is built from one of eight fixed centre frequencies. Half the tone spacing is added for a logic 1 and subtracted for a logic 0. The tone spacing follows the selected baud rate and is either equal to it or half of it.

The block paces the data source. A one-cycle bit strobe marks the last cycle of every bit period. The transmit bit and all configuration inputs are captured in that cycle, so a carrier, baud or spacing change made mid-bit waits for the next bit boundary. The accumulator is never disturbed on a tone change, only its step.

Its outputs are a square-wave carrier (the accumulator MSB) and the top accumulator bits, which an external sine table can use. While the enable input is low, the accumulator is cleared and the carrier is held low.

Top module: `fsk_modulator`

## Requirements
- R1: After reset, with txEnable low, carrierOut is 0, phaseOut is 0, bitStrobe is 0 and cfgError is 0.
- R2: carrierSel codes 0..7 select centre frequencies of 60000, 66000, 72000, 76000, 82050, 86000, 110000 and 132500 Hz. The per-cycle accumulator step is floor(c*2^32/16e6) + floor(h*2^32/16e6) when the captured data bit is 1, and floor(c*2^32/16e6) - floor(h*2^32/16e6) when it is 0. Here c is the centre frequency and h is half the tone spacing, both in Hz.
- R3: baudSel code k selects 600*2^k baud. A bit period lasts floor(16e6/baud) clock cycles: 26666, 13333, 6666 or 3333 cycles.
- R4: With halfDev = 0 the tone spacing equals the baud rate (h = baud/2). With halfDev = 1 the spacing is half the baud rate (h = baud/4).
- R5: halfDev = 1 together with baudSel = 0 is not allowed. The block then uses a spacing equal to the baud rate and drives cfgError high for as long as that captured setting is in use.
- R6: While enabled, bitStrobe is high for exactly one cycle, the last cycle of each bit period. txData, carrierSel, baudSel and halfDev are captured in that cycle and govern the following bit. They are also captured in every cycle while txEnable is low, so the first bit uses the values present in the last disabled cycle. The first strobe comes in the cycle after (period - 1) enabled clock edges.
- R7: A change of txData, carrierSel, baudSel or halfDev between bit boundaries does not affect the step, the bit period or cfgError until the next bitStrobe cycle.
- R8: A tone change never resets the accumulator. After n edges with step s0 and then m edges with step s1, the accumulator holds n*s0 + m*s1 modulo 2^32.
- R9: When txEnable is low, carrierOut is 0 in that same cycle and bitStrobe is 0. From the next clock edge the accumulator and phaseOut are 0, and the bit counter restarts.
- R10: phaseOut is accumulator bits 31..24, and carrierOut equals accumulator bit 31 while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txEnable | input | 1 | Runs modulation while high |
| txData | input | 1 | Serial transmit bit, captured on bitStrobe |
| carrierSel | input | 3 | Centre frequency select |
| baudSel | input | 2 | Baud rate select |
| halfDev | input | 1 | 1 = spacing is half the baud rate |
| bitStrobe | output | 1 | One-cycle pulse at each bit boundary |
| carrierOut | output | 1 | Square-wave carrier |
| phaseOut | output | 8 | Top accumulator bits for a sine lookup |
| cfgError | output | 1 | Half spacing requested at 600 baud |

## Verification
The hardest case to reach from the ports is a configuration change landing on the strobe cycle, followed by another change in the middle of the next bit. Only the accumulated phase shows which step was applied on which edge. The stimulus counts enabled edges from the enable rise up to the strobe cycle and changes the data there. It then changes the carrier mid-bit and counts the edges to the next boundary. The expected phase is a sum of exact edge counts times independently computed steps, so one cycle of misalignment, or a phase reset, shows up in phaseOut. Separate runs at 600 and 4800 baud confirm the strobe period, and a 600-baud half-spacing vector confirms that the forced spacing and the error flag appear together.

// File: rtl/fsk_mod_pkg.sv
package fsk_mod_pkg;
  localparam int SEL_W        = 3;
  localparam int BAUD_W       = 2;
  localparam int NUM_CARRIERS = 1 << SEL_W;
  localparam int NUM_BAUDS    = 1 << BAUD_W;
  localparam int BASE_BAUD    = 600;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [BAUD_W-1:0] baud;
    logic              halfDev;
    logic              data;
  } txCfg_t;

  typedef struct packed {
    logic run;   // modulation active
    logic load;  // capture inputs for the next bit
  } ctrlStrobe_t;

  function automatic longint unsigned carrierHz(input int code);
    case (code)
      0: return 64'd60000;
      1: return 64'd66000;
      2: return 64'd72000;
      3: return 64'd76000;
      4: return 64'd82050;
      5: return 64'd86000;
      6: return 64'd110000;
      default: return 64'd132500;
    endcase
  endfunction

  function automatic longint unsigned baudHz(input int code);
    return longint'(BASE_BAUD) << code;
  endfunction

  // half of the tone spacing; half spacing is refused at the lowest rate
  function automatic longint unsigned halfSpacingHz(input int code, input bit halfDev);
    longint unsigned b;
    b = baudHz(code);
    return (halfDev && code != 0) ? b / 4 : b / 2;
  endfunction

  function automatic longint unsigned hzToStep(input longint unsigned hz,
                                               input longint unsigned clkHz,
                                               input int accW);
    return (hz << accW) / clkHz;
  endfunction
endpackage

// File: rtl/fsk_mod_ctrl.sv
module fsk_mod_ctrl
  import fsk_mod_pkg::*;
#(
  parameter int CLK_HZ = 16_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic [BAUD_W-1:0] baudSel,
  input  logic              halfDev,
  output ctrlStrobe_t       strobes,
  output logic              bitStrobe,
  output logic              cfgError
);
  localparam int MAX_PERIOD = CLK_HZ / BASE_BAUD;
  localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

  logic [CNT_W-1:0]  periodLast [NUM_BAUDS];
  logic [CNT_W-1:0]  bitCnt;
  logic [BAUD_W-1:0] baudCur;
  logic              halfDevCur;
  logic              atLast;

  for (genvar b = 0; b < NUM_BAUDS; b++) begin : g_period
    assign periodLast[b] = CNT_W'(longint'(CLK_HZ) / baudHz(b) - 1);
  end

  assign atLast       = (bitCnt == periodLast[baudCur]);
  assign bitStrobe    = txEnable && atLast;
  assign strobes.run  = txEnable;
  assign strobes.load = !txEnable || atLast;
  assign cfgError     = halfDevCur && (baudCur == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     bitCnt <= '0;
    else if (!txEnable || atLast)  bitCnt <= '0;
    else                           bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baudCur    <= '0;
      halfDevCur <= 1'b0;
    end else if (strobes.load) begin
      baudCur    <= baudSel;
      halfDevCur <= halfDev;
    end
  end
endmodule

// File: rtl/fsk_mod_datapath.sv
module fsk_mod_datapath
  import fsk_mod_pkg::*;
#(
  parameter int CLK_HZ  = 16_000_000,
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  txCfg_t             cfgIn,
  input  ctrlStrobe_t        strobes,
  output logic               carrierOut,
  output logic [PHASE_W-1:0] phaseOut
);
  localparam int HALF_IDX_W = BAUD_W + 1;
  localparam logic [ACC_W-1:0] RESET_STEP =
    ACC_W'(hzToStep(carrierHz(NUM_CARRIERS - 1), CLK_HZ, ACC_W));

  logic [ACC_W-1:0]      centreStep [NUM_CARRIERS];
  logic [ACC_W-1:0]      halfStep   [2*NUM_BAUDS];
  logic [HALF_IDX_W-1:0] halfIdx;
  logic [ACC_W-1:0]      nextStep;
  logic [ACC_W-1:0]      stepReg;
  logic [ACC_W-1:0]      acc;

  for (genvar c = 0; c < NUM_CARRIERS; c++) begin : g_centre
    assign centreStep[c] = ACC_W'(hzToStep(carrierHz(c), CLK_HZ, ACC_W));
  end

  for (genvar b = 0; b < NUM_BAUDS; b++) begin : g_baud
    for (genvar d = 0; d < 2; d++) begin : g_dev
      assign halfStep[2*b+d] =
        ACC_W'(hzToStep(halfSpacingHz(b, d != 0), CLK_HZ, ACC_W));
    end
  end

  assign halfIdx  = {cfgIn.baud, cfgIn.halfDev};
  assign nextStep = cfgIn.data ? centreStep[cfgIn.sel] + halfStep[halfIdx]
                               : centreStep[cfgIn.sel] - halfStep[halfIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             stepReg <= RESET_STEP;
    else if (strobes.load) stepReg <= nextStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             acc <= '0;
    else if (!strobes.run) acc <= '0;
    else                   acc <= acc + stepReg;
  end

  assign carrierOut = strobes.run && acc[ACC_W-1];
  assign phaseOut   = acc[ACC_W-1 -: PHASE_W];
endmodule

// File: rtl/fsk_modulator.sv
module fsk_modulator
  import fsk_mod_pkg::*;
#(
  parameter int CLK_HZ  = 16_000_000,
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txEnable,
  input  logic               txData,
  input  logic [SEL_W-1:0]   carrierSel,
  input  logic [BAUD_W-1:0]  baudSel,
  input  logic               halfDev,
  output logic               bitStrobe,
  output logic               carrierOut,
  output logic [PHASE_W-1:0] phaseOut,
  output logic               cfgError
);
  txCfg_t      liveCfg;
  ctrlStrobe_t strobes;

  assign liveCfg = '{sel: carrierSel, baud: baudSel, halfDev: halfDev, data: txData};

  fsk_mod_ctrl #(.CLK_HZ(CLK_HZ)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .baudSel(baudSel),
    .halfDev(halfDev), .strobes(strobes), .bitStrobe(bitStrobe),
    .cfgError(cfgError)
  );

  fsk_mod_datapath #(.CLK_HZ(CLK_HZ), .ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgIn(liveCfg), .strobes(strobes),
    .carrierOut(carrierOut), .phaseOut(phaseOut)
  );
endmodule

// File: rtl/fsk_modulator_chk.sv
module fsk_modulator_chk #(
  parameter int PHASE_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               txEnable,
  input logic               bitStrobe,
  input logic               carrierOut,
  input logic [PHASE_W-1:0] phaseOut,
  input logic               cfgError
);
  // R6: the strobe never lasts two cycles
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |=> !bitStrobe);

  // R9: nothing is emitted while disabled
  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |-> (!carrierOut && !bitStrobe));

  // R9: accumulator cleared one edge after a disabled cycle
  p_phase_cleared_r9: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> (phaseOut == '0));

  // R7: the error flag only moves at a bit boundary while running
  p_cfgerr_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && $past(txEnable) && !$past(bitStrobe)) |-> $stable(cfgError));
endmodule

bind fsk_modulator fsk_modulator_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rstN(rstN), .txEnable(txEnable), .bitStrobe(bitStrobe),
  .carrierOut(carrierOut), .phaseOut(phaseOut), .cfgError(cfgError)
);

// File: tb/sim_fsk_modulator.sv
`timescale 1ns/1ps
module sim_fsk_modulator;
  localparam real CLK_PERIOD = 62.5;
  localparam longint unsigned FCLK = 64'd16000000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEnable = 1'b0;
  logic       txData = 1'b0;
  logic [2:0] carrierSel = 3'd7;
  logic [1:0] baudSel = 2'd0;
  logic       halfDev = 1'b0;
  logic       bitStrobe, carrierOut, cfgError;
  logic [7:0] phaseOut;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsk_modulator u0 (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .txData(txData),
    .carrierSel(carrierSel), .baudSel(baudSel), .halfDev(halfDev),
    .bitStrobe(bitStrobe), .carrierOut(carrierOut), .phaseOut(phaseOut),
    .cfgError(cfgError)
  );

  typedef struct packed {
    bit [2:0]  sel;
    bit [1:0]  baud;
    bit        dev;
    bit        data;
    bit [11:0] edges;
    bit        err;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd7, 2'd3, 1'b0, 1'b1, 12'd1000, 1'b0},
    '{3'd0, 2'd2, 1'b1, 1'b0, 12'd2047, 1'b0},
    '{3'd1, 2'd1, 1'b0, 1'b1, 12'd3001, 1'b0},
    '{3'd2, 2'd0, 1'b1, 1'b1, 12'd1500, 1'b1},
    '{3'd3, 2'd0, 1'b0, 1'b0, 12'd999,  1'b0},
    '{3'd4, 2'd3, 1'b1, 1'b1, 12'd3000, 1'b0},
    '{3'd5, 2'd1, 1'b1, 1'b0, 12'd777,  1'b0},
    '{3'd6, 2'd2, 1'b0, 1'b0, 12'd2500, 1'b0}
  };

  function automatic bit [31:0] expStep(input int sel, input int baud,
                                        input bit dev, input bit data);
    longint unsigned cHz [8] = '{60000, 66000, 72000, 76000, 82050, 86000, 110000, 132500};
    longint unsigned b, h, cs, hs;
    b  = 64'd600 << baud;
    h  = (dev && baud != 0) ? b / 4 : b / 2;
    cs = (cHz[sel] << 32) / FCLK;
    hs = (h << 32) / FCLK;
    return data ? 32'(cs + hs) : 32'(cs - hs);
  endfunction

  task automatic chk(input string tag, input longint actual, input longint expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit [31:0] s0, s1, s2, accExp;
    step(3);
    // R1: reset state
    chk("R1 carrierOut", carrierOut, 0);
    chk("R1 phaseOut", phaseOut, 0);
    chk("R1 bitStrobe", bitStrobe, 0);
    chk("R1 cfgError", cfgError, 0);
    rstN = 1'b1;
    step(2);

    // R2 R4 R5 R10: vector table
    for (int i = 0; i < 8; i++) begin
      txEnable = 1'b0;
      carrierSel = VECS[i].sel; baudSel = VECS[i].baud;
      halfDev = VECS[i].dev; txData = VECS[i].data;
      step(1);
      txEnable = 1'b1;
      step(int'(VECS[i].edges));
      accExp = expStep(VECS[i].sel, VECS[i].baud, VECS[i].dev, VECS[i].data)
               * 32'(VECS[i].edges);
      chk($sformatf("R2 R4 phaseOut vec%0d", i), phaseOut, accExp[31:24]);
      chk($sformatf("R10 carrierOut vec%0d", i), carrierOut, accExp[31]);
      chk($sformatf("R5 cfgError vec%0d", i), cfgError, VECS[i].err);
      chk($sformatf("R6 no strobe mid-bit vec%0d", i), bitStrobe, 0);
      txEnable = 1'b0;
      #1;
      chk($sformatf("R9 carrier off at once vec%0d", i), carrierOut, 0);
      step(1);
      chk($sformatf("R9 phase cleared vec%0d", i), phaseOut, 0);
      chk($sformatf("R9 no strobe vec%0d", i), bitStrobe, 0);
    end

    // R3 R6 R7 R8: boundary timing at 4800 baud
    carrierSel = 3'd5; baudSel = 2'd3; halfDev = 1'b0; txData = 1'b0;
    step(1);
    txEnable = 1'b1;
    s0 = expStep(5, 3, 1'b0, 1'b0);
    s1 = expStep(5, 3, 1'b0, 1'b1);
    s2 = expStep(0, 3, 1'b0, 1'b0);
    step(3331);
    chk("R6 no strobe one early", bitStrobe, 0);
    step(1);
    chk("R6 strobe at last cycle", bitStrobe, 1);
    txData = 1'b1;
    step(1);
    chk("R6 strobe one cycle", bitStrobe, 0);
    accExp = s0 * 32'd3333;
    chk("R8 phase at boundary", phaseOut, accExp[31:24]);
    step(100);
    accExp = s0 * 32'd3333 + s1 * 32'd100;
    chk("R8 phase continuous", phaseOut, accExp[31:24]);
    carrierSel = 3'd0; txData = 1'b0;
    step(50);
    accExp = s0 * 32'd3333 + s1 * 32'd150;
    chk("R7 mid-bit change ignored", phaseOut, accExp[31:24]);
    step(3182);
    chk("R3 second strobe after 3333", bitStrobe, 1);
    step(11);
    accExp = s0 * 32'd3333 + s1 * 32'd3333 + s2 * 32'd10;
    chk("R7 change applied after boundary", phaseOut, accExp[31:24]);

    // R3 R5: 600 baud period, error flag follows the captured setting
    txEnable = 1'b0;
    baudSel = 2'd0; halfDev = 1'b1;
    step(1);
    chk("R5 flag raised", cfgError, 1);
    txEnable = 1'b1;
    halfDev = 1'b0;
    step(26664);
    chk("R7 flag held mid-bit", cfgError, 1);
    chk("R3 no strobe before 26666", bitStrobe, 0);
    step(1);
    chk("R3 strobe at 26666", bitStrobe, 1);
    step(1);
    chk("R5 flag dropped after boundary", cfgError, 0);

    txEnable = 1'b0;
    step(2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule